// File: doc/BRIEF.md
# Packed byte set-less-than unit

This block carries out one SIMD instruction on a small register file: a compare across four byte lanes. Each cycle it may accept a 32-bit instruction word with a valid strobe and a separate 3-bit minor opcode. From the word it decodes a destination index and two source indices. It reads the two 32-bit sources combinationally and compares them lane by lane, as signed or unsigned bytes. On the next clock edge it writes back a packed word in which every byte is 0x00 or 0x01.

The register index space has 16 entries. Index 0 is a constant zero that cannot be written, and indices 1 to 15 are physical 32-bit registers. A nonzero padding field, or a destination of index 0, makes the instruction a silent no-op. A minor opcode that the block does not execute raises an unsupported flag for one cycle. A load port lets surrounding logic, or a bench, place operand values in the registers. A registered debug port returns the value of any register.

Top module: `byte_slt_unit`

## Requirements
- R1: Field positions are fixed. `ins_word[9:6]` is the destination index, `ins_word[13:10]` is source b and `ins_word[17:14]` is source c. The result is visible at the register one clock edge after the cycle in which `ins_valid` is high.
- R2: Minor opcode 6 selects the signed compare. Lane i occupies bits [8i+7:8i] and is read as two's complement from -128 to 127. Result lane i is 1 when lane i of b is less than lane i of c, and 0 otherwise.
- R3: Minor opcode 7 selects the unsigned compare. Each lane is read as 0 to 255, and the rule for setting each lane is the same as in R2.
- R4: Every result lane is either 0x00 or 0x01, so bits [7:1] of each lane are always zero.
- R5: If `ins_word[25:21]` is nonzero, the instruction changes no register.
- R6: A destination index of 0 changes no register. A source index of 0 reads as zero.
- R7: When the two source indices are equal, including when both are 0, the destination is written with 0x00000000.
- R8: With `ins_valid` high and a minor opcode other than 6 or 7, `unsup_flag` is high on the following cycle only and no register changes. In every other case `unsup_flag` is low.
- R9: Synchronous active-high `rst` clears all 15 registers and `unsup_flag` to zero.
- R10: With `ld_en` high, `ld_data` is written to register `ld_idx` on the clock edge, and a load to index 0 is ignored. If an instruction writes in the same cycle, the instruction write wins and the load is dropped.
- R11: `dbg_data` returns the register named by `dbg_idx` one clock edge later, and index 0 returns zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ins_valid | input | 1 | Instruction word is present this cycle |
| ins_word | input | 32 | Instruction word holding the index and padding fields |
| ins_minor | input | 3 | Minor opcode: 6 for signed, 7 for unsigned |
| ld_en | input | 1 | Load strobe |
| ld_idx | input | 4 | Register index to load |
| ld_data | input | 32 | Value to load |
| dbg_idx | input | 4 | Register index to read |
| dbg_data | output | 32 | Registered value of the register named by dbg_idx |
| unsup_flag | output | 1 | One-cycle pulse for a minor opcode the block does not execute |

## Verification
The hardest situation to reach from the ports is a same-cycle collision between the load port and an instruction writing the same register. The bench creates it by raising `ld_en` and `ins_valid` on the same edge with a matching destination, then reads the register back through the debug port. The sign boundary is also hard to reach. To hit it, the vector table places 0x7F, 0x80, 0xFF and 0x00 in the same lane of b and c, so that the signed and unsigned results differ in each lane. Each no-op case is checked against a sentinel value loaded beforehand into the destination.

// File: rtl/slt_pkg.sv
package slt_pkg;
  localparam logic [2:0] MINOR_SLT_S = 3'd6;
  localparam logic [2:0] MINOR_SLT_U = 3'd7;

  localparam int DST_LSB = 6;
  localparam int SRCB_LSB = 10;
  localparam int SRCC_LSB = 14;
  localparam int PAD_LSB = 21;
  localparam int PAD_W = 5;

  typedef enum logic [1:0] {
    CMP_NONE = 2'd0,
    CMP_SIGNED = 2'd1,
    CMP_UNSIGNED = 2'd2
  } cmp_mode_e;
endpackage

// File: rtl/slt_decode.sv
module slt_decode
  import slt_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int IDX_W = 4
) (
  input  logic              valid,
  input  logic [WORD_W-1:0] word,
  input  logic [2:0]        minor,
  output logic [IDX_W-1:0]  idx_d,
  output logic [IDX_W-1:0]  idx_b,
  output logic [IDX_W-1:0]  idx_c,
  output cmp_mode_e         mode,
  output logic              wr_en,
  output logic              unsup
);
  logic [PAD_W-1:0] pad;
  logic             known;

  always_comb begin
    idx_d = word[DST_LSB +: IDX_W];
    idx_b = word[SRCB_LSB +: IDX_W];
    idx_c = word[SRCC_LSB +: IDX_W];
    pad   = word[PAD_LSB +: PAD_W];
    unique case (minor)
      MINOR_SLT_S: mode = CMP_SIGNED;
      MINOR_SLT_U: mode = CMP_UNSIGNED;
      default:     mode = CMP_NONE;
    endcase
    known = (mode != CMP_NONE);
    wr_en = valid && known && (pad == '0) && (idx_d != '0);
    unsup = valid && !known;
  end
endmodule

// File: rtl/slt_lanes.sv
module slt_lanes
  import slt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8
) (
  input  logic [DATA_W-1:0] opb,
  input  logic [DATA_W-1:0] opc,
  input  cmp_mode_e         mode,
  output logic [DATA_W-1:0] res
);
  localparam int LANES = DATA_W / LANE_W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] lb, lc;
    logic              lt;
    assign lb = opb[i*LANE_W +: LANE_W];
    assign lc = opc[i*LANE_W +: LANE_W];
    always_comb begin
      if (mode == CMP_SIGNED) lt = $signed(lb) < $signed(lc);
      else                    lt = lb < lc;
    end
    assign res[i*LANE_W +: LANE_W] = {{(LANE_W-1){1'b0}}, lt};
  end
endmodule

// File: rtl/slt_regfile.sv
module slt_regfile #(
  parameter int DATA_W = 32,
  parameter int IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ridx_b,
  output logic [DATA_W-1:0] rdata_b,
  input  logic [IDX_W-1:0]  ridx_c,
  output logic [DATA_W-1:0] rdata_c,
  input  logic [IDX_W-1:0]  didx,
  output logic [DATA_W-1:0] ddata
);
  localparam int NREG = (1 << IDX_W) - 1;

  logic [DATA_W-1:0] mem [1:NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 1; k <= NREG; k++) mem[k] <= '0;
    end else if (we && widx != '0) begin
      mem[widx] <= wdata;
    end
  end

  assign rdata_b = (ridx_b == '0) ? '0 : mem[ridx_b];
  assign rdata_c = (ridx_c == '0) ? '0 : mem[ridx_c];

  always_ff @(posedge clk) begin
    if (rst)              ddata <= '0;
    else if (didx == '0)  ddata <= '0;
    else                  ddata <= mem[didx];
  end

  assert_reset_clears_R9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rdata_b == '0 && rdata_c == '0));

  assert_dbg_zero_index_R11: assert property (@(posedge clk) disable iff (rst)
    ($past(didx) == '0) |-> (ddata == '0));
endmodule

// File: rtl/byte_slt_unit.sv
module byte_slt_unit
  import slt_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANE_W = 8,
  parameter int IDX_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ins_valid,
  input  logic [31:0]       ins_word,
  input  logic [2:0]        ins_minor,
  input  logic              ld_en,
  input  logic [IDX_W-1:0]  ld_idx,
  input  logic [DATA_W-1:0] ld_data,
  input  logic [IDX_W-1:0]  dbg_idx,
  output logic [DATA_W-1:0] dbg_data,
  output logic              unsup_flag
);
  logic [IDX_W-1:0]  idx_d, idx_b, idx_c;
  cmp_mode_e         mode;
  logic              dec_wr, dec_unsup;
  logic [DATA_W-1:0] opb, opc, cmp_res;
  logic              we;
  logic [IDX_W-1:0]  widx;
  logic [DATA_W-1:0] wdata;

  slt_decode #(.WORD_W(32), .IDX_W(IDX_W)) u_dec (
    .valid(ins_valid), .word(ins_word), .minor(ins_minor),
    .idx_d(idx_d), .idx_b(idx_b), .idx_c(idx_c),
    .mode(mode), .wr_en(dec_wr), .unsup(dec_unsup)
  );

  slt_lanes #(.DATA_W(DATA_W), .LANE_W(LANE_W)) u_lanes (
    .opb(opb), .opc(opc), .mode(mode), .res(cmp_res)
  );

  always_comb begin
    if (dec_wr) begin
      we = 1'b1;
      widx = idx_d;
      wdata = cmp_res;
    end else begin
      we = ld_en && (ld_idx != '0);
      widx = ld_idx;
      wdata = ld_data;
    end
  end

  slt_regfile #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_rf (
    .clk(clk), .rst(rst), .we(we), .widx(widx), .wdata(wdata),
    .ridx_b(idx_b), .rdata_b(opb), .ridx_c(idx_c), .rdata_c(opc),
    .didx(dbg_idx), .ddata(dbg_data)
  );

  always_ff @(posedge clk) begin
    if (rst) unsup_flag <= 1'b0;
    else     unsup_flag <= dec_unsup;
  end

  assert_pad_blocks_write_R5: assert property (@(posedge clk) disable iff (rst)
    (ins_valid && ins_word[PAD_LSB +: PAD_W] != '0) |-> !we || !dec_wr);

  assert_same_src_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (dec_wr && idx_b == idx_c) |-> (wdata == '0));

  assert_unsup_origin_R8: assert property (@(posedge clk) disable iff (rst)
    unsup_flag |-> ($past(ins_valid) && $past(ins_minor) != MINOR_SLT_S
                    && $past(ins_minor) != MINOR_SLT_U));

  assert_no_write_on_unsup_R8: assert property (@(posedge clk) disable iff (rst)
    dec_unsup |-> !dec_wr);
endmodule

// File: tb/tb_byte_slt_unit.sv
module tb_byte_slt_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ins_valid = 1'b0;
  logic [31:0] ins_word = '0;
  logic [2:0]  ins_minor = '0;
  logic        ld_en = 1'b0;
  logic [3:0]  ld_idx = '0;
  logic [31:0] ld_data = '0;
  logic [3:0]  dbg_idx = '0;
  logic [31:0] dbg_data;
  logic        unsup_flag;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  byte_slt_unit dut (
    .clk(clk), .rst(rst), .ins_valid(ins_valid), .ins_word(ins_word),
    .ins_minor(ins_minor), .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .dbg_idx(dbg_idx), .dbg_data(dbg_data), .unsup_flag(unsup_flag)
  );

  // {b, c, unsigned_mode, expected}
  localparam logic [96:0] VEC [7] = '{
    {32'h01807F00, 32'h027F8000, 1'b0, 32'h01010000},
    {32'h01807F00, 32'h027F8000, 1'b1, 32'h01000100},
    {32'hFF00FF10, 32'h00FFFE20, 1'b0, 32'h01000001},
    {32'hFF00FF10, 32'h00FFFE20, 1'b1, 32'h00010001},
    {32'h00000000, 32'hFFFFFFFF, 1'b1, 32'h01010101},
    {32'h00000000, 32'hFFFFFFFF, 1'b0, 32'h00000000},
    {32'h80808080, 32'h7F7F7F7F, 1'b0, 32'h01010101}
  };

  function automatic logic [31:0] enc(input logic [4:0] pad, input logic [3:0] c,
                                      input logic [3:0] b, input logic [3:0] d);
    return (32'(pad) << 21) | (32'(c) << 14) | (32'(b) << 10) | (32'(d) << 6);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [3:0] idx, input logic [31:0] val);
    @(negedge clk);
    ld_en = 1'b1; ld_idx = idx; ld_data = val;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic exec(input logic [31:0] word, input logic [2:0] minor);
    @(negedge clk);
    ins_valid = 1'b1; ins_word = word; ins_minor = minor;
    @(negedge clk);
    ins_valid = 1'b0; ins_word = '0;
  endtask

  task automatic rd(input logic [3:0] idx, output logic [31:0] val);
    @(negedge clk);
    dbg_idx = idx;
    @(negedge clk);
    val = dbg_data;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    // preload nonzero values, then reset must clear them
    repeat (2) @(negedge clk);
    rst = 1'b0;
    load(4'd5, 32'h12345678);
    load(4'd15, 32'hCAFEF00D);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    rd(4'd5, v);  check("R9 reset reg5", v, 32'h0);
    rd(4'd15, v); check("R9 reset reg15", v, 32'h0);
    check("R9 reset flag", {31'b0, unsup_flag}, 32'h0);

    // table walk: b in r1, c in r2, dest r3
    for (int i = 0; i < 7; i++) begin
      load(4'd1, VEC[i][96:65]);
      load(4'd2, VEC[i][64:33]);
      exec(enc(5'd0, 4'd2, 4'd1, 4'd3), VEC[i][32] ? 3'd7 : 3'd6);
      check("R1 no unsup on valid op", {31'b0, unsup_flag}, 32'h0);
      rd(4'd3, v);
      check(VEC[i][32] ? "R3 unsigned lanes R4" : "R2 signed lanes R4", v, VEC[i][31:0]);
    end

    // R1 latency: result present at register right after the edge
    load(4'd1, 32'h00000001); load(4'd2, 32'h00000002);
    @(negedge clk);
    ins_valid = 1'b1; ins_word = enc(5'd0, 4'd2, 4'd1, 4'd4); ins_minor = 3'd7;
    dbg_idx = 4'd4;
    @(negedge clk);
    ins_valid = 1'b0;
    @(negedge clk);
    check("R1 one-edge write", dbg_data, 32'h00000001);

    // R5 padding nonzero
    load(4'd3, 32'hDEADBEEF);
    exec(enc(5'd1, 4'd2, 4'd1, 4'd3), 3'd6);
    rd(4'd3, v); check("R5 pad low bit", v, 32'hDEADBEEF);
    exec(enc(5'd16, 4'd2, 4'd1, 4'd3), 3'd7);
    rd(4'd3, v); check("R5 pad high bit", v, 32'hDEADBEEF);

    // R6 dest 0: nothing changes, r0 still zero
    exec(enc(5'd0, 4'd2, 4'd1, 4'd0), 3'd7);
    rd(4'd0, v); check("R6 dest0 r0", v, 32'h0);
    rd(4'd3, v); check("R6 dest0 r3", v, 32'hDEADBEEF);

    // R6 source 0 reads zero: 0 < 2 in lane0 unsigned
    exec(enc(5'd0, 4'd2, 4'd0, 4'd3), 3'd7);
    rd(4'd3, v); check("R6 src0 zero", v, 32'h00000001);

    // R7 equal sources
    load(4'd3, 32'hDEADBEEF);
    exec(enc(5'd0, 4'd1, 4'd1, 4'd3), 3'd7);
    rd(4'd3, v); check("R7 same src", v, 32'h0);
    load(4'd3, 32'hDEADBEEF);
    exec(enc(5'd0, 4'd0, 4'd0, 4'd3), 3'd6);
    rd(4'd3, v); check("R7 both zero", v, 32'h0);

    // R8 unsupported minor
    load(4'd3, 32'hDEADBEEF);
    exec(enc(5'd0, 4'd2, 4'd1, 4'd3), 3'd3);
    check("R8 flag high", {31'b0, unsup_flag}, 32'h1);
    @(negedge clk);
    check("R8 flag one cycle", {31'b0, unsup_flag}, 32'h0);
    rd(4'd3, v); check("R8 no write", v, 32'hDEADBEEF);
    exec(enc(5'd0, 4'd2, 4'd1, 4'd3), 3'd0);
    check("R8 flag minor0", {31'b0, unsup_flag}, 32'h1);

    // R10 load to zero ignored, collision priority
    load(4'd0, 32'hFFFFFFFF);
    rd(4'd0, v); check("R10 load r0 ignored", v, 32'h0);
    load(4'd1, 32'h00000005); load(4'd2, 32'h00000009);
    @(negedge clk);
    ins_valid = 1'b1; ins_word = enc(5'd0, 4'd2, 4'd1, 4'd6); ins_minor = 3'd7;
    ld_en = 1'b1; ld_idx = 4'd6; ld_data = 32'hA5A5A5A5;
    @(negedge clk);
    ins_valid = 1'b0; ld_en = 1'b0;
    rd(4'd6, v); check("R10 instr wins", v, 32'h00000001);
    load(4'd7, 32'h0BADCAFE);
    rd(4'd7, v); check("R10 load ok", v, 32'h0BADCAFE);

    // R11 debug registered
    @(negedge clk); dbg_idx = 4'd7;
    @(negedge clk); dbg_idx = 4'd0;
    check("R11 dbg value", dbg_data, 32'h0BADCAFE);
    @(negedge clk);
    check("R11 dbg zero", dbg_data, 32'h0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule